// File: doc/BRIEF.md
# Multiplexed Bus Host Sequencer

This block is the host-side master of a 16-bit bus on which addresses and data share the same wires. A user-side client presents one request at a time: a read or a write, a 14-bit word address, 16 bits of write data and a two-bit byte-lane enable. The sequencer converts that request into a timed series of chip-select, address-latch, read and write-strobe levels. When the access is complete it returns a one-cycle completion pulse, together with the captured word on reads.

The sequencer remembers the last address it latched into the target. Chip select stays high for a parameterised number of idle cycles after each access. If the next request arrives while the select is still up and names the same address, the address phase is skipped and only the read or write strobe is repeated. When the idle hold runs out, chip select drops and the remembered address is forgotten, so the next access always latches afresh. Byte enables drive the low-lane and high-lane write strobes independently. The bus is released for a full cycle before read rises.

States: `ST_IDLE` (waiting, ready high), `ST_ADDR` (address driven, latch low), `ST_LATCH` (latch high for `AL_CYC` cycles), `ST_HOLD` (latch low, address held), `ST_TURN` (bus released before read), `ST_READ` (read high for `ACC_CYC` cycles), `ST_WDATA` (write data set up), `ST_STROBE` (write strobes high for `WR_CYC` cycles) and `ST_WEND` (strobes low, data still driven). Transitions: IDLE→ADDR on an accepted request without an address hit, IDLE→TURN on a read hit, IDLE→WDATA on a write hit, ADDR→LATCH, LATCH→HOLD when its count ends, HOLD→TURN for reads or HOLD→WDATA for writes, TURN→READ, READ→IDLE when the access count ends, WDATA→STROBE, STROBE→WEND when its count ends, and WEND→IDLE.

Top module: `mbus_host_seq`

## Requirements
- R1: During reset chip select, address latch, read, both write strobes, output enable and done are all low, and ready is high.
- R2: A request with no address hit is sequenced as follows: one cycle with the address driven and latch low, then `AL_CYC` cycles with latch high, then one cycle with latch low and the address still driven, then one cycle of bus release (for reads), then read high for `ACC_CYC` cycles.
- R3: Read data is sampled from the bus input in the last cycle that read is high. It appears on `rsp_rdata` in the following cycle, which is also the cycle in which `rsp_done` is high.
- R4: A write drives the write data on the bus for one cycle before the strobes rise, for the `WR_CYC` strobe cycles, and for one more cycle after they fall. Done follows in the next cycle.
- R5: During the strobe phase `bus_wrl` equals byte-enable bit 0 and `bus_wrh` equals bit 1. Enables of 2'b11 pulse both strobes in the same cycles, and 2'b00 pulses neither.
- R6: When chip select is still high and the request address equals the last latched address, the address phase is skipped. A read goes straight to bus release and a write goes straight to data setup.
- R7: Chip select rises on the clock edge that accepts a request. It stays high through the access and for `HOLD_CYC` idle cycles after the done cycle; the done cycle is the first of these. It then drops unless a request is accepted on that edge. Dropping it forgets the latched address.
- R8: Read and address latch are never high in a cycle in which either write strobe is high.
- R9: Output enable is low in the cycle before read rises and in every cycle in which read is high. It is high during every write-strobe cycle and in the cycle after the strobes fall.
- R10: Ready is high only in the idle state. A request is taken only when ready is high, and requests presented while busy have no effect. Done is a single-cycle pulse.
- R11: During the address phase the bus output carries the 14-bit address in bits 13:0 with bits 15:14 at zero. During the data phase it carries the full 16-bit write word; the low byte is in bits 7:0 and the high byte in bits 15:8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 14 | Word address |
| req_wdata | input | 16 | Write word |
| req_be | input | 2 | Byte-lane enables, bit 0 low lane, bit 1 high lane |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| rsp_rdata | output | 16 | Captured read word |
| rsp_done | output | 1 | One-cycle completion pulse |
| bus_cs | output | 1 | Chip select, active high |
| bus_al | output | 1 | Address latch strobe |
| bus_rd | output | 1 | Read strobe |
| bus_wrl | output | 1 | Low-lane write strobe |
| bus_wrh | output | 1 | High-lane write strobe |
| bus_dout | output | 16 | Value driven onto the shared bus |
| bus_oe | output | 1 | Drive enable for `bus_dout` |
| bus_din | input | 16 | Value read from the shared bus |

## Verification
The assertions assume that the timing parameters are at least one. They also assume that the target drives `bus_din` only while read is high and that the value sampled in the last read cycle is the one wanted. The bench's target model follows this: it returns a marker word in every earlier read cycle and the stored word only in the last one, so a capture taken one cycle too early is caught. Requests are held valid through busy periods, with their address and data changed, to show that nothing is taken until ready is high. Idle gaps are chosen both to land exactly on the last cycle of the chip-select hold and to run past it.

// File: rtl/mbus_pkg.sv
package mbus_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_LATCH,
        ST_HOLD,
        ST_TURN,
        ST_READ,
        ST_WDATA,
        ST_STROBE,
        ST_WEND
    } mbus_state_e;

    function automatic int max_of4(input int a, input int b, input int c, input int d);
        int m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/mbus_phase_timer.sv
module mbus_phase_timer #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart,
    input  logic [CW-1:0] len,
    output logic          last
);
    logic [CW-1:0] cnt_q;

    assign last = (cnt_q == len - CW'(1));

    // Counts cycles spent in the current state; saturates on the final one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (!last) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/mbus_addr_track.sv
module mbus_addr_track #(
    parameter int AW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_addr,
    input  logic          clear,
    input  logic [AW-1:0] cmp_addr,
    output logic          hit,
    output logic          valid
);
    logic [AW-1:0] last_q;
    logic          valid_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            last_q  <= '0;
        end else if (clear) begin
            valid_q <= 1'b0;
        end else if (load) begin
            valid_q <= 1'b1;
            last_q  <= load_addr;
        end
    end

    assign hit   = valid_q && (last_q == cmp_addr);
    assign valid = valid_q;
endmodule

// File: rtl/mbus_host_seq.sv
module mbus_host_seq
    import mbus_pkg::*;
#(
    parameter int AW       = 14,
    parameter int DW       = 16,
    parameter int AL_CYC   = 2,
    parameter int ACC_CYC  = 3,
    parameter int WR_CYC   = 2,
    parameter int HOLD_CYC = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic          req_write,
    input  logic [AW-1:0] req_addr,
    input  logic [DW-1:0] req_wdata,
    input  logic [1:0]    req_be,
    output logic          req_ready,
    output logic [DW-1:0] rsp_rdata,
    output logic          rsp_done,
    output logic          bus_cs,
    output logic          bus_al,
    output logic          bus_rd,
    output logic          bus_wrl,
    output logic          bus_wrh,
    output logic [DW-1:0] bus_dout,
    output logic          bus_oe,
    input  logic [DW-1:0] bus_din
);
    localparam int MAXLEN = max_of4(AL_CYC, ACC_CYC, WR_CYC, HOLD_CYC);
    localparam int CW     = $clog2(MAXLEN + 1);

    mbus_state_e   state_q, state_d;
    logic          accept, t_last, restart, cs_q, cs_drop;
    logic          hit, trk_valid, wr_q, done_q;
    logic [CW-1:0] len;
    logic [AW-1:0] addr_q;
    logic [DW-1:0] wdata_q, rdata_q, addr_ext;
    logic [1:0]    be_q;

    assign accept   = req_valid && (state_q == ST_IDLE);
    assign restart  = (state_d != state_q);
    assign cs_drop  = (state_q == ST_IDLE) && cs_q && t_last && !accept;
    assign addr_ext = {{(DW-AW){1'b0}}, addr_q};

    always_comb begin
        unique case (state_q)
            ST_LATCH:  len = CW'(AL_CYC);
            ST_READ:   len = CW'(ACC_CYC);
            ST_STROBE: len = CW'(WR_CYC);
            ST_IDLE:   len = CW'(HOLD_CYC);
            default:   len = CW'(1);
        endcase
    end

    mbus_phase_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .len     (len),
        .last    (t_last)
    );

    mbus_addr_track #(.AW(AW)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == ST_LATCH),
        .load_addr (addr_q),
        .clear     (cs_drop),
        .cmp_addr  (req_addr),
        .hit       (hit),
        .valid     (trk_valid)
    );

    // Next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = hit ? (req_write ? ST_WDATA : ST_TURN) : ST_ADDR;
            ST_ADDR:   state_d = ST_LATCH;
            ST_LATCH:  if (t_last) state_d = ST_HOLD;
            ST_HOLD:   state_d = wr_q ? ST_WDATA : ST_TURN;
            ST_TURN:   state_d = ST_READ;
            ST_READ:   if (t_last) state_d = ST_IDLE;
            ST_WDATA:  state_d = ST_STROBE;
            ST_STROBE: if (t_last) state_d = ST_WEND;
            ST_WEND:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Request capture, chip select, completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_q    <= 1'b0;
            done_q  <= 1'b0;
            wr_q    <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            rdata_q <= '0;
        end else begin
            if (accept) begin
                wr_q    <= req_write;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
            end
            if (accept)       cs_q <= 1'b1;
            else if (cs_drop) cs_q <= 1'b0;
            done_q <= ((state_q == ST_READ) && t_last) || (state_q == ST_WEND);
            if ((state_q == ST_READ) && t_last) rdata_q <= bus_din;
        end
    end

    // Bus outputs decoded from the state
    always_comb begin
        bus_al   = 1'b0;
        bus_rd   = 1'b0;
        bus_wrl  = 1'b0;
        bus_wrh  = 1'b0;
        bus_oe   = 1'b0;
        bus_dout = '0;
        unique case (state_q)
            ST_ADDR, ST_HOLD: begin
                bus_oe   = 1'b1;
                bus_dout = addr_ext;
            end
            ST_LATCH: begin
                bus_oe   = 1'b1;
                bus_al   = 1'b1;
                bus_dout = addr_ext;
            end
            ST_READ: bus_rd = 1'b1;
            ST_WDATA, ST_WEND: begin
                bus_oe   = 1'b1;
                bus_dout = wdata_q;
            end
            ST_STROBE: begin
                bus_oe   = 1'b1;
                bus_dout = wdata_q;
                bus_wrl  = be_q[0];
                bus_wrh  = be_q[1];
            end
            default: ;
        endcase
    end

    assign bus_cs    = cs_q;
    assign req_ready = (state_q == ST_IDLE);
    assign rsp_done  = done_q;
    assign rsp_rdata = rdata_q;

    // R8: read and latch stay low while any write strobe is high
    a_r8_no_rd_al_with_wr: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wrl || bus_wrh) |-> !(bus_rd || bus_al));
    // R9: bus released the cycle before read rises
    a_r9_oe_low_before_rd: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_rd) |-> !$past(bus_oe));
    // R9: bus never driven while read is high
    a_r9_oe_low_during_rd: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |-> !bus_oe);
    // R9: data still driven when a write strobe falls
    a_r9_oe_held_at_wr_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(bus_wrl) || $fell(bus_wrh)) |-> bus_oe);
    // R10: done is a single-cycle pulse seen only in idle
    a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r10_done_in_idle: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> req_ready);
    // R7: a remembered address implies chip select is up
    a_r7_valid_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        trk_valid |-> bus_cs);
    // R2: latch only pulses with chip select high
    a_r2_al_needs_cs: assert property (@(posedge clk) disable iff (!rst_n)
        bus_al |-> bus_cs);
endmodule

// File: tb/sim_mbus_host_seq.sv
module sim_mbus_host_seq;
    localparam int CLK_PERIOD = 10;
    localparam int AL   = 2;
    localparam int ACC  = 3;
    localparam int WR   = 2;
    localparam int HOLD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [13:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_done;
    logic [15:0] rsp_rdata;
    logic        bus_cs, bus_al, bus_rd, bus_wrl, bus_wrh, bus_oe;
    logic [15:0] bus_dout;
    logic [15:0] bus_din = 16'hBAD0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbus_host_seq #(.AL_CYC(AL), .ACC_CYC(ACC), .WR_CYC(WR), .HOLD_CYC(HOLD)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
        .req_ready(req_ready), .rsp_rdata(rsp_rdata), .rsp_done(rsp_done),
        .bus_cs(bus_cs), .bus_al(bus_al), .bus_rd(bus_rd), .bus_wrl(bus_wrl),
        .bus_wrh(bus_wrh), .bus_dout(bus_dout), .bus_oe(bus_oe), .bus_din(bus_din)
    );

    int checks = 0;
    int failures = 0;

    function automatic logic [15:0] dflt(input logic [13:0] a);
        return 16'h5A5A ^ {2'b00, a};
    endfunction

    // ---------------- target model on the bus ----------------
    logic [15:0] slv_mem [int];
    logic [13:0] slv_addr = '0;
    int          rd_cnt = 0;

    function automatic logic [15:0] slv_get(input logic [13:0] a);
        if (slv_mem.exists(int'(a))) return slv_mem[int'(a)];
        return dflt(a);
    endfunction

    always @(posedge clk) begin
        logic [15:0] t;
        t = slv_get(slv_addr);
        if (bus_wrl) t[7:0]  = bus_dout[7:0];
        if (bus_wrh) t[15:8] = bus_dout[15:8];
        if (bus_wrl || bus_wrh) slv_mem[int'(slv_addr)] = t;
        if (bus_al) slv_addr <= bus_dout[13:0];
        rd_cnt <= bus_rd ? rd_cnt + 1 : 0;
    end

    always @(negedge clk) begin
        bus_din <= (bus_rd && rd_cnt == ACC-1) ? slv_get(slv_addr) : 16'hBAD0;
    end

    // ---------------- reference model ----------------
    typedef struct {
        logic cs, al, rd, wrl, wrh, oe, done, ready, rchk, skip, isdata;
        logic [15:0] dout, rdata;
    } exp_t;

    exp_t        q[$];
    exp_t        cur;
    logic [15:0] ref_mem [int];
    logic        m_cs = 1'b0, m_valid = 1'b0;
    logic [13:0] m_last = '0;
    int          m_idle = 0;

    function automatic logic [15:0] ref_get(input logic [13:0] a);
        if (ref_mem.exists(int'(a))) return ref_mem[int'(a)];
        return dflt(a);
    endfunction

    function automatic exp_t mkv(input logic al, rd, wrl, wrh, oe,
                                 input logic [15:0] d, input logic isdata, skip);
        exp_t e;
        e.cs = 1'b1; e.al = al; e.rd = rd; e.wrl = wrl; e.wrh = wrh; e.oe = oe;
        e.done = 1'b0; e.ready = 1'b0; e.rchk = 1'b0; e.skip = skip;
        e.isdata = isdata; e.dout = d; e.rdata = '0;
        return e;
    endfunction

    function automatic exp_t idle_v(input logic cs);
        exp_t e;
        e = mkv(0, 0, 0, 0, 0, 16'h0, 0, 0);
        e.cs = cs; e.ready = 1'b1;
        return e;
    endfunction

    task automatic build(input logic w, input logic [13:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        logic  hit;
        exp_t  e;
        logic [15:0] t;
        hit  = m_cs && m_valid && (m_last == a);
        m_cs = 1'b1;
        if (!hit) begin
            q.push_back(mkv(0, 0, 0, 0, 1, {2'b00, a}, 0, 0));
            for (int i = 0; i < AL; i++) q.push_back(mkv(1, 0, 0, 0, 1, {2'b00, a}, 0, 0));
            q.push_back(mkv(0, 0, 0, 0, 1, {2'b00, a}, 0, 0));
            m_valid = 1'b1;
            m_last  = a;
        end
        if (!w) begin
            q.push_back(mkv(0, 0, 0, 0, 0, 16'h0, 0, hit));
            for (int i = 0; i < ACC; i++) q.push_back(mkv(0, 1, 0, 0, 0, 16'h0, 0, hit));
            e = idle_v(1'b1);
            e.done = 1'b1; e.rchk = 1'b1; e.rdata = ref_get(a);
            q.push_back(e);
        end else begin
            q.push_back(mkv(0, 0, 0, 0, 1, d, 1, hit));
            for (int i = 0; i < WR; i++) q.push_back(mkv(0, 0, be[0], be[1], 1, d, 1, hit));
            q.push_back(mkv(0, 0, 0, 0, 1, d, 1, hit));
            e = idle_v(1'b1);
            e.done = 1'b1;
            q.push_back(e);
            t = ref_get(a);
            if (be[0]) t[7:0]  = d[7:0];
            if (be[1]) t[15:8] = d[15:8];
            ref_mem[int'(a)] = t;
        end
    endtask

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic compare_cur();
        string tseq;
        tseq = cur.skip ? "R6" : "R2";
        chk(bus_cs === cur.cs, "R7", "bus_cs", 16'(bus_cs), 16'(cur.cs));
        chk(bus_al === cur.al, tseq, "bus_al", 16'(bus_al), 16'(cur.al));
        chk(bus_rd === cur.rd, tseq, "bus_rd", 16'(bus_rd), 16'(cur.rd));
        chk(bus_wrl === cur.wrl, "R5", "bus_wrl", 16'(bus_wrl), 16'(cur.wrl));
        chk(bus_wrh === cur.wrh, "R5", "bus_wrh", 16'(bus_wrh), 16'(cur.wrh));
        chk(bus_oe === cur.oe, "R9", "bus_oe", 16'(bus_oe), 16'(cur.oe));
        if (cur.oe)
            chk(bus_dout === cur.dout, cur.isdata ? "R4" : "R11", "bus_dout", bus_dout, cur.dout);
        chk(rsp_done === cur.done, "R10", "rsp_done", 16'(rsp_done), 16'(cur.done));
        chk(req_ready === cur.ready, "R10", "req_ready", 16'(req_ready), 16'(cur.ready));
        if (cur.rchk)
            chk(rsp_rdata === cur.rdata, "R3", "rsp_rdata", rsp_rdata, cur.rdata);
        chk(!((bus_wrl || bus_wrh) && (bus_rd || bus_al)), "R8", "rd/al with write",
            {12'h0, bus_rd, bus_al, bus_wrl, bus_wrh}, 16'h0);
    endtask

    // One cycle: compare, drive, advance the model, move to the next sampling point.
    task automatic step(input logic v, w, input logic [13:0] a, input logic [15:0] d,
                        input logic [1:0] be, output bit acc);
        compare_cur();
        req_valid = v; req_write = w; req_addr = a; req_wdata = d; req_be = be;
        acc = v && cur.ready;
        if (acc) build(w, a, d, be);
        if (q.size() > 0) begin
            cur = q.pop_front();
            if (cur.done) m_idle = 0;
        end else begin
            if (m_cs && m_idle == HOLD-1) begin
                m_cs    = 1'b0;
                m_valid = 1'b0;
            end
            if (m_idle < HOLD-1) m_idle++;
            cur = idle_v(m_cs);
        end
        @(negedge clk);
    endtask

    task automatic issue(input logic w, input logic [13:0] a, input logic [15:0] d,
                         input logic [1:0] be);
        bit acc;
        acc = 1'b0;
        while (!acc) step(1'b1, w, a, d, be, acc);
    endtask

    task automatic idle(input int n);
        bit acc;
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 14'h0, 16'h0, 2'b00, acc);
    endtask

    // Wait out the current access while holding a busy-time request that must be ignored (R10).
    task automatic finish_busy(input logic [13:0] junk_a);
        bit acc;
        acc = 1'b0;
        while (!cur.ready) step(1'b1, 1'b1, junk_a, 16'hFFFF, 2'b11, acc);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL R10 watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(bus_cs === 1'b0 && bus_al === 1'b0 && bus_rd === 1'b0, "R1", "cs/al/rd",
            {13'h0, bus_cs, bus_al, bus_rd}, 16'h0);
        chk(bus_wrl === 1'b0 && bus_wrh === 1'b0 && bus_oe === 1'b0, "R1", "wrl/wrh/oe",
            {13'h0, bus_wrl, bus_wrh, bus_oe}, 16'h0);
        chk(req_ready === 1'b1 && rsp_done === 1'b0, "R1", "ready/done",
            {14'h0, req_ready, rsp_done}, 16'h2);
        rst_n = 1'b1;
        cur = idle_v(1'b0);

        idle(2);
        issue(1'b1, 14'h0123, 16'hA5C3, 2'b11);   // full write, both strobes
        issue(1'b0, 14'h0123, 16'h0, 2'b00);      // same address: skipped latch (R6)
        issue(1'b1, 14'h0123, 16'h00FF, 2'b01);   // low lane only (R5)
        issue(1'b1, 14'h0123, 16'h7700, 2'b10);   // high lane only (R5)
        issue(1'b0, 14'h0123, 16'h0, 2'b00);      // expect 77FF (R3)
        finish_busy(14'h0200);                    // busy-time request ignored (R10)
        idle(HOLD + 4);                           // chip select drops (R7)
        issue(1'b0, 14'h0123, 16'h0, 2'b00);      // full read after drop (R7)
        issue(1'b0, 14'h3FFF, 16'h0, 2'b00);      // new address, full read (R11)
        issue(1'b1, 14'h3FFF, 16'hFFFF, 2'b00);   // no strobes (R5)
        issue(1'b0, 14'h3FFF, 16'h0, 2'b00);      // unchanged default word
        issue(1'b1, 14'h0000, 16'h1111, 2'b11);   // full write elsewhere
        finish_busy(14'h0000);
        idle(HOLD - 1);                           // accept on last hold cycle (R7)
        issue(1'b0, 14'h0000, 16'h0, 2'b00);      // still a hit (R6)
        finish_busy(14'h1555);
        idle(HOLD + 2);
        issue(1'b1, 14'h2AAA, 16'hBEEF, 2'b11);
        issue(1'b0, 14'h2AAA, 16'h0, 2'b00);
        finish_busy(14'h0001);
        idle(HOLD + 2);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule